// File: doc/BRIEF.md
# Message Register Handshake Controller

This block is the servant end of a word-serial message exchange on a 16-bit address bus slave. A remote sender writes a 16-bit or 32-bit message into two data words, called message-high and message-low. It coordinates with the block through a status word, the response register. That word carries four flags: a claim flag (LOCK), a location monitor for the high word (ABMH), a read-ready flag (RRDY) and a write-ready flag (WRDY). A fixed identity word, the protocol register, describes the unit as a bus-master servant/commander with no signal register and no fast handshake.

The bus port sees four registers in a 64-byte window. The window starts at FE00h plus 40h times a 3-bit logical address. A local processor port reaches the same four registers by a 2-bit select, and message accesses through either port have the same side effects. Several senders share the block through the claim flag. A bus read of the response register returns the word as it stood and then clears LOCK. A sender that saw both LOCK and WRDY set owns the message slot. A 32-bit message writes the high word first and then the low word. A 16-bit message writes only the low word, which leaves ABMH set. The local side re-arms the slot, posts outgoing data and acknowledges the incoming-message interrupt.

The local port is valid/ready. The block lowers `loc_ready` only when a bus access hits the same register in the same cycle. The local side must then hold `loc_write`, `loc_sel` and `loc_wdata` stable with `loc_valid` high until it sees `loc_ready` high. A local request is applied only in a cycle where both signals are high. The bus port has no back-pressure. An address hit is taken in the cycle it is presented.

Top module: `msg_handshake_ctrl`

## Requirements
- R1: A bus access is taken (`bus_hit` = 1) only when `bus_addr` lies in the window FE00h + 40h × `ula` and its offset in the window is 08h (protocol), 0Ah (response), 0Ch (message-high) or 0Eh (message-low). Any other address has no effect, and `bus_rdata` reads 0000h for it.
- R2: In the response word, LOCK is bit 15, ABMH bit 14, RRDY bit 10 and WRDY bit 9, and every other bit reads 1. A bus read of the response word returns the value before the read, and LOCK is 0 from the next cycle. A local read of the response word leaves LOCK unchanged.
- R3: A write of message-low from either port clears WRDY and sets `irq_msg` in the next cycle. `irq_msg` stays high until a cycle with `irq_ack` and no new message-low write. A write in the same cycle as `irq_ack` wins.
- R4: A read of message-low from either port clears RRDY in the next cycle.
- R5: Any read or write of message-high, from either port, clears ABMH in the next cycle.
- R6: `arm` sets LOCK, ABMH and WRDY to 1. When a clearing access to the same flag falls in the same cycle, the clear wins.
- R7: `post_valid` loads `post_hi` into message-high and `post_lo` into message-low, and sets RRDY. A port write to a word in the same cycle wins over the posted value for that word.
- R8: The protocol word reads 8FF0h on both ports. Writes to the protocol or response word from either port change nothing.
- R9: When the bus and the local port access the same register in one cycle, `loc_ready` is 0 and only the bus access takes effect. A held local request is applied in the next cycle with no bus conflict. Accesses to different registers are both applied in the same cycle.
- R10: After reset, the response word reads 39FFh (all four flags 0), `irq_msg` is 0 and both message words read 0000h.
- R11: Data written to a message word through either port is read back unchanged on either port. Read data is valid combinationally in the cycle the access is accepted, and reads 0000h otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ula | input | 3 | Logical address selecting the register window |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus byte address |
| bus_wdata | input | 16 | Bus write data |
| bus_hit | output | 1 | Bus access decoded to one of the four registers |
| bus_rdata | output | 16 | Bus read data for an accepted read |
| loc_valid | input | 1 | Local request valid |
| loc_ready | output | 1 | Local request accepted this cycle |
| loc_write | input | 1 | Local 1 = write, 0 = read |
| loc_sel | input | 2 | Local register: 0 protocol, 1 response, 2 message-high, 3 message-low |
| loc_wdata | input | 16 | Local write data |
| loc_rdata | output | 16 | Local read data for an accepted read |
| arm | input | 1 | Re-arm the slot: set LOCK, ABMH and WRDY |
| post_valid | input | 1 | Load outgoing data and set RRDY |
| post_hi | input | 16 | Outgoing message-high value |
| post_lo | input | 16 | Outgoing message-low value |
| irq_ack | input | 1 | Acknowledge the incoming-message interrupt |
| irq_msg | output | 1 | Incoming-message interrupt pending |

## Verification
Two kinds of operation can fall in the same cycle. The first is a bus access and a local access to the same register. The bench drives a bus read of the response word and a local read of it together, and also a bus write and a local write of message-low together. It judges the result by `loc_ready` being low, the bus value taking effect, and the held local write landing one cycle later. The second is a local flag operation against a clearing access. The bench issues `arm` together with a message-low write, and `irq_ack` together with a local message-low write. It then reads back the response word and `irq_msg` to confirm that the clear and the new interrupt win.

// File: rtl/msgh_pkg.sv
package msgh_pkg;

  // Register select, shared by the bus decoder and the local port.
  // The bus decoder maps window offset bits [2:1] onto these values.
  typedef enum logic [1:0] {
    SEL_PROTO = 2'd0,
    SEL_RESP  = 2'd1,
    SEL_MHI   = 2'd2,
    SEL_MLO   = 2'd3
  } reg_sel_e;

  // Flag positions inside the response word
  localparam int LOCK_BIT = 15;
  localparam int ABMH_BIT = 14;
  localparam int RRDY_BIT = 10;
  localparam int WRDY_BIT = 9;

  // Unused response bits read as one
  localparam logic [15:0] RESP_FILL =
    ~((16'd1 << LOCK_BIT) | (16'd1 << ABMH_BIT) |
      (16'd1 << RRDY_BIT) | (16'd1 << WRDY_BIT));

  // Identity word: bus-master servant/commander, no signal register,
  // no fast handshake
  localparam logic [15:0] PROTO_WORD = 16'h8FF0;

  typedef struct packed {
    logic lock;
    logic abmh;
    logic rrdy;
    logic wrdy;
  } flags_t;

endpackage

// File: rtl/msgh_addr_dec.sv
module msgh_addr_dec
  import msgh_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ULA_W     = 3,
  parameter int BASE_ADDR = 'hFE00,
  parameter int STRIDE    = 'h40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ULA_W-1:0]  ula,
  output logic              hit,
  output reg_sel_e          sel
);
  localparam int WIN_BITS = $clog2(STRIDE);
  localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'(STRIDE - 1);

  logic [ADDR_W-1:0] win_base;
  logic [WIN_BITS-1:0] offs;
  logic in_window;
  logic slot_ok;

  always_comb begin
    win_base  = ADDR_W'(BASE_ADDR) + (ADDR_W'(STRIDE) * ADDR_W'(ula));
    in_window = ((addr & ~WIN_MASK) == (win_base & ~WIN_MASK));
    offs      = addr[WIN_BITS-1:0];
    // Registers sit at offsets 08h, 0Ah, 0Ch, 0Eh of the window
    slot_ok   = (offs[WIN_BITS-1:4] == '0) && offs[3] && !offs[0];
    hit       = in_window && slot_ok;
    sel       = reg_sel_e'(offs[2:1]);
  end

endmodule

// File: rtl/msgh_arb.sv
module msgh_arb
  import msgh_pkg::*;
(
  input  logic     bus_act,
  input  reg_sel_e bus_sel,
  input  logic     loc_valid,
  input  reg_sel_e loc_sel,
  output logic     loc_ready,
  output logic     loc_act
);
  // The bus wins a same-register conflict; the local side waits a cycle.
  logic clash;

  always_comb begin
    clash     = bus_act && loc_valid && (bus_sel == loc_sel);
    loc_ready = !clash;
    loc_act   = loc_valid && !clash;
  end

endmodule

// File: rtl/msgh_status.sv
module msgh_status
  import msgh_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_resp_bus_rd,
  input  logic   ev_hi_acc,
  input  logic   ev_lo_wr,
  input  logic   ev_lo_rd,
  input  logic   arm,
  input  logic   post_valid,
  input  logic   irq_ack,
  output flags_t flags,
  output logic   irq_msg
);
  flags_t flags_d;
  logic   irq_d;

  // Clears driven by register accesses take priority over local sets.
  always_comb begin
    flags_d = flags;
    if (arm) begin
      flags_d.lock = 1'b1;
      flags_d.abmh = 1'b1;
      flags_d.wrdy = 1'b1;
    end
    if (post_valid)     flags_d.rrdy = 1'b1;
    if (ev_resp_bus_rd) flags_d.lock = 1'b0;
    if (ev_hi_acc)      flags_d.abmh = 1'b0;
    if (ev_lo_wr)       flags_d.wrdy = 1'b0;
    if (ev_lo_rd)       flags_d.rrdy = 1'b0;

    irq_d = irq_msg;
    if (irq_ack)  irq_d = 1'b0;
    if (ev_lo_wr) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      irq_msg <= 1'b0;
    end else begin
      flags   <= flags_d;
      irq_msg <= irq_d;
    end
  end

  assert_lock_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resp_bus_rd |=> !flags.lock);

  assert_wrdy_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lo_wr |=> (!flags.wrdy && irq_msg));

  assert_irq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_msg && !irq_ack) |=> irq_msg);

  assert_rrdy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lo_rd |=> !flags.rrdy);

  assert_abmh_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hi_acc |=> !flags.abmh);

  assert_arm_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !ev_resp_bus_rd) |=> flags.lock);

endmodule

// File: rtl/msgh_msgregs.sv
module msgh_msgregs
  import msgh_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  reg_sel_e          bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              loc_we,
  input  reg_sel_e          loc_sel,
  input  logic [DATA_W-1:0] loc_wdata,
  input  logic              post_valid,
  input  logic [DATA_W-1:0] post_hi,
  input  logic [DATA_W-1:0] post_lo,
  output logic [DATA_W-1:0] msg_hi,
  output logic [DATA_W-1:0] msg_lo
);
  localparam int NWORDS = 2;

  logic [DATA_W-1:0] word_q    [NWORDS];
  logic [DATA_W-1:0] post_word [NWORDS];

  assign post_word[0] = post_hi;
  assign post_word[1] = post_lo;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam reg_sel_e MY_SEL = (w == 0) ? SEL_MHI : SEL_MLO;
    logic bus_hit_w;
    logic loc_hit_w;

    assign bus_hit_w = bus_we && (bus_sel == MY_SEL);
    assign loc_hit_w = loc_we && (loc_sel == MY_SEL);

    // Priority: bus write, then local write, then posted data
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          word_q[w] <= '0;
      else if (bus_hit_w)  word_q[w] <= bus_wdata;
      else if (loc_hit_w)  word_q[w] <= loc_wdata;
      else if (post_valid) word_q[w] <= post_word[w];
    end

    assert_post_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (post_valid && !bus_hit_w && !loc_hit_w) |=> (word_q[w] == $past(post_word[w])));
  end

  assign msg_hi = word_q[0];
  assign msg_lo = word_q[1];

endmodule

// File: rtl/msg_handshake_ctrl.sv
module msg_handshake_ctrl
  import msgh_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int ULA_W     = 3,
  parameter int BASE_ADDR = 'hFE00,
  parameter int STRIDE    = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ULA_W-1:0]  ula,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_hit,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              loc_valid,
  output logic              loc_ready,
  input  logic              loc_write,
  input  logic [1:0]        loc_sel,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata,
  input  logic              arm,
  input  logic              post_valid,
  input  logic [DATA_W-1:0] post_hi,
  input  logic [DATA_W-1:0] post_lo,
  input  logic              irq_ack,
  output logic              irq_msg
);
  reg_sel_e bus_sel;
  reg_sel_e lsel;
  logic     bus_act;
  logic     loc_act;
  flags_t   flags;
  logic [DATA_W-1:0] msg_hi;
  logic [DATA_W-1:0] msg_lo;
  logic [DATA_W-1:0] resp_word;

  logic bus_rd, bus_wr, loc_rd, loc_wr;
  logic ev_resp_bus_rd, ev_hi_acc, ev_lo_wr, ev_lo_rd;

  assign lsel = reg_sel_e'(loc_sel);

  msgh_addr_dec #(
    .ADDR_W(ADDR_W), .ULA_W(ULA_W), .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE)
  ) u_dec (
    .addr (bus_addr),
    .ula  (ula),
    .hit  (bus_hit),
    .sel  (bus_sel)
  );

  assign bus_act = bus_valid && bus_hit;

  msgh_arb u_arb (
    .bus_act   (bus_act),
    .bus_sel   (bus_sel),
    .loc_valid (loc_valid),
    .loc_sel   (lsel),
    .loc_ready (loc_ready),
    .loc_act   (loc_act)
  );

  always_comb begin
    bus_rd = bus_act && !bus_write;
    bus_wr = bus_act && bus_write;
    loc_rd = loc_act && !loc_write;
    loc_wr = loc_act && loc_write;

    ev_resp_bus_rd = bus_rd && (bus_sel == SEL_RESP);
    ev_hi_acc      = (bus_act && (bus_sel == SEL_MHI)) ||
                     (loc_act && (lsel == SEL_MHI));
    ev_lo_wr       = (bus_wr && (bus_sel == SEL_MLO)) ||
                     (loc_wr && (lsel == SEL_MLO));
    ev_lo_rd       = (bus_rd && (bus_sel == SEL_MLO)) ||
                     (loc_rd && (lsel == SEL_MLO));
  end

  msgh_status u_status (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_resp_bus_rd (ev_resp_bus_rd),
    .ev_hi_acc      (ev_hi_acc),
    .ev_lo_wr       (ev_lo_wr),
    .ev_lo_rd       (ev_lo_rd),
    .arm            (arm),
    .post_valid     (post_valid),
    .irq_ack        (irq_ack),
    .flags          (flags),
    .irq_msg        (irq_msg)
  );

  msgh_msgregs #(.DATA_W(DATA_W)) u_msg (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_wr),
    .bus_sel    (bus_sel),
    .bus_wdata  (bus_wdata),
    .loc_we     (loc_wr),
    .loc_sel    (lsel),
    .loc_wdata  (loc_wdata),
    .post_valid (post_valid),
    .post_hi    (post_hi),
    .post_lo    (post_lo),
    .msg_hi     (msg_hi),
    .msg_lo     (msg_lo)
  );

  always_comb begin
    resp_word           = DATA_W'(RESP_FILL);
    resp_word[LOCK_BIT] = flags.lock;
    resp_word[ABMH_BIT] = flags.abmh;
    resp_word[RRDY_BIT] = flags.rrdy;
    resp_word[WRDY_BIT] = flags.wrdy;
  end

  function automatic logic [DATA_W-1:0] pick(input reg_sel_e s,
                                             input logic [DATA_W-1:0] rw,
                                             input logic [DATA_W-1:0] hi,
                                             input logic [DATA_W-1:0] lo);
    case (s)
      SEL_PROTO: pick = DATA_W'(PROTO_WORD);
      SEL_RESP:  pick = rw;
      SEL_MHI:   pick = hi;
      default:   pick = lo;
    endcase
  endfunction

  // Read data shows the value before this cycle's side effects land.
  assign bus_rdata = bus_rd ? pick(bus_sel, resp_word, msg_hi, msg_lo) : '0;
  assign loc_rdata = loc_rd ? pick(lsel, resp_word, msg_hi, msg_lo) : '0;

  assert_stall_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_valid && !loc_ready) |-> bus_act);

  assert_nohit_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hit |-> (bus_rdata == '0));

endmodule

// File: tb/msg_handshake_ctrl_test.sv
module msg_handshake_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  ula;
  logic        bus_valid, bus_write;
  logic [15:0] bus_addr, bus_wdata;
  logic        bus_hit;
  logic [15:0] bus_rdata;
  logic        loc_valid, loc_ready, loc_write;
  logic [1:0]  loc_sel;
  logic [15:0] loc_wdata, loc_rdata;
  logic        arm, post_valid, irq_ack, irq_msg;
  logic [15:0] post_hi, post_lo;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_handshake_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ula(ula),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_hit(bus_hit), .bus_rdata(bus_rdata),
    .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_write(loc_write),
    .loc_sel(loc_sel), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
    .arm(arm), .post_valid(post_valid), .post_hi(post_hi), .post_lo(post_lo),
    .irq_ack(irq_ack), .irq_msg(irq_msg)
  );

  typedef struct packed {
    logic        bv; logic bw; logic [15:0] ba; logic [15:0] bd;
    logic        lv; logic lw; logic [1:0]  ls; logic [15:0] ld;
    logic        arm; logic post; logic ack;
    logic        cb; logic [15:0] eb;
    logic        cl; logic [15:0] el; logic elr;
    logic [15:0] ersp; logic eirq;
    logic [3:0]  req;
  } vec_t;

  // ula = 3: window FEC0h; protocol FEC8, response FECA, high FECC, low FECE.
  // Posted data is A5A5h (high) and 5A5Ah (low).
  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    // R8 R10: protocol word on the bus, reset flags
    '{1,0,16'hFEC8,16'h0, 0,0,0,16'h0, 0,0,0, 1,16'h8FF0, 0,16'h0,1, 16'h39FF,0, 4'd8},
    // R6: arm sets LOCK ABMH WRDY
    '{0,0,16'h0,16'h0, 0,0,0,16'h0, 1,0,0, 0,16'h0, 0,16'h0,1, 16'hFBFF,0, 4'd6},
    // R2: first reader sees LOCK set, then LOCK clears
    '{1,0,16'hFECA,16'h0, 0,0,0,16'h0, 0,0,0, 1,16'hFBFF, 0,16'h0,1, 16'h7BFF,0, 4'd2},
    // R2: second reader sees LOCK clear
    '{1,0,16'hFECA,16'h0, 0,0,0,16'h0, 0,0,0, 1,16'h7BFF, 0,16'h0,1, 16'h7BFF,0, 4'd2},
    // R6: re-arm
    '{0,0,16'h0,16'h0, 0,0,0,16'h0, 1,0,0, 0,16'h0, 0,16'h0,1, 16'hFBFF,0, 4'd6},
    // R5: high-word write clears ABMH
    '{1,1,16'hFECC,16'h1234, 0,0,0,16'h0, 0,0,0, 0,16'h0, 0,16'h0,1, 16'hBBFF,0, 4'd5},
    // R3: low-word write clears WRDY, raises irq
    '{1,1,16'hFECE,16'h5678, 0,0,0,16'h0, 0,0,0, 0,16'h0, 0,16'h0,1, 16'hB9FF,1, 4'd3},
    // R11 R9: bus reads high, local reads low, same cycle
    '{1,0,16'hFECC,16'h0, 1,0,3,16'h0, 0,0,0, 1,16'h1234, 1,16'h5678,1, 16'hB9FF,1, 4'd11},
    // R3: irq held
    '{0,0,16'h0,16'h0, 0,0,0,16'h0, 0,0,0, 0,16'h0, 0,16'h0,1, 16'hB9FF,1, 4'd3},
    // R3: ack clears irq
    '{0,0,16'h0,16'h0, 0,0,0,16'h0, 0,0,1, 0,16'h0, 0,16'h0,1, 16'hB9FF,0, 4'd3},
    // R7: post sets RRDY
    '{0,0,16'h0,16'h0, 0,0,0,16'h0, 0,1,0, 0,16'h0, 0,16'h0,1, 16'hBDFF,0, 4'd7},
    // R4: bus read of low returns posted data, clears RRDY
    '{1,0,16'hFECE,16'h0, 0,0,0,16'h0, 0,0,0, 1,16'h5A5A, 0,16'h0,1, 16'hB9FF,0, 4'd4},
    // R6: arm again
    '{0,0,16'h0,16'h0, 0,0,0,16'h0, 1,0,0, 0,16'h0, 0,16'h0,1, 16'hFBFF,0, 4'd6},
    // R1: response offset in the wrong window: no data, LOCK kept
    '{1,0,16'hFE8A,16'h0, 0,0,0,16'h0, 0,0,0, 1,16'h0000, 0,16'h0,1, 16'hFBFF,0, 4'd1},
    // R1: unused offset in the right window
    '{1,0,16'hFEC2,16'h0, 0,0,0,16'h0, 0,0,0, 1,16'h0000, 0,16'h0,1, 16'hFBFF,0, 4'd1},
    // R8: writes to response (bus) and protocol (local) ignored
    '{1,1,16'hFECA,16'h0000, 1,1,0,16'h0000, 0,0,0, 0,16'h0, 0,16'h0,1, 16'hFBFF,0, 4'd8},
    // R9: bus and local read response together: local stalled, LOCK cleared by bus
    '{1,0,16'hFECA,16'h0, 1,0,1,16'h0, 0,0,0, 1,16'hFBFF, 1,16'h0000,0, 16'h7BFF,0, 4'd9},
    // R6: arm with a low write: WRDY clear wins, LOCK set
    '{1,1,16'hFECE,16'h0001, 0,0,0,16'h0, 1,0,0, 0,16'h0, 0,16'h0,1, 16'hF9FF,1, 4'd6},
    // R3: ack with a local low write: irq stays set
    '{0,0,16'h0,16'h0, 1,1,3,16'h0002, 0,0,1, 0,16'h0, 0,16'h0,1, 16'hF9FF,1, 4'd3},
    // R5: local read of high clears ABMH
    '{0,0,16'h0,16'h0, 1,0,2,16'h0, 0,0,0, 0,16'h0, 1,16'hA5A5,1, 16'hB9FF,1, 4'd5},
    // R7: post again
    '{0,0,16'h0,16'h0, 0,0,0,16'h0, 0,1,0, 0,16'h0, 0,16'h0,1, 16'hBDFF,1, 4'd7},
    // R4: local read of low clears RRDY
    '{0,0,16'h0,16'h0, 1,0,3,16'h0, 0,0,0, 0,16'h0, 1,16'h5A5A,1, 16'hB9FF,1, 4'd4}
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    loc_valid = 0; loc_write = 0; loc_sel = 0; loc_wdata = 0;
    arm = 0; post_valid = 0; irq_ack = 0;
  endtask

  // Local read of the response word has no side effect (R2).
  task automatic peek_resp(input string req, input logic [15:0] exp_rsp,
                           input logic exp_irq);
    idle();
    loc_valid = 1; loc_sel = 2'd1;
    #1;
    chk(req, "response word", loc_rdata, exp_rsp);
    chk(req, "irq_msg", {15'd0, irq_msg}, {15'd0, exp_irq});
  endtask

  initial begin
    rst_n = 0; ula = 3'd3; post_hi = 16'hA5A5; post_lo = 16'h5A5A;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    peek_resp("R10", 16'h39FF, 1'b0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].req);
      @(negedge clk);
      idle();
      bus_valid = VECS[i].bv; bus_write = VECS[i].bw;
      bus_addr  = VECS[i].ba; bus_wdata = VECS[i].bd;
      loc_valid = VECS[i].lv; loc_write = VECS[i].lw;
      loc_sel   = VECS[i].ls; loc_wdata = VECS[i].ld;
      arm = VECS[i].arm; post_valid = VECS[i].post; irq_ack = VECS[i].ack;
      #1;
      if (VECS[i].cb) chk(rq, "bus_rdata", bus_rdata, VECS[i].eb);
      if (VECS[i].cl) chk(rq, "loc_rdata", loc_rdata, VECS[i].el);
      chk(rq, "loc_ready", {15'd0, loc_ready}, {15'd0, VECS[i].elr});
      @(negedge clk);
      peek_resp(rq, VECS[i].ersp, VECS[i].eirq);
    end

    // R9: same-register write clash; the held local write lands next cycle
    @(negedge clk);
    idle();
    bus_valid = 1; bus_write = 1; bus_addr = 16'hFECE; bus_wdata = 16'h1111;
    loc_valid = 1; loc_write = 1; loc_sel = 2'd3; loc_wdata = 16'h2222;
    #1;
    chk("R9", "loc_ready in clash", {15'd0, loc_ready}, 16'd0);
    @(negedge clk);
    bus_valid = 0;
    #1;
    chk("R9", "loc_ready when held", {15'd0, loc_ready}, 16'd1);
    @(negedge clk);
    idle();
    bus_valid = 1; bus_addr = 16'hFECE;
    #1;
    chk("R9", "low word after held local write", bus_rdata, 16'h2222);

    // R1: bus_hit follows the logical address
    @(negedge clk);
    idle();
    bus_valid = 1; bus_addr = 16'hFEC8;
    #1;
    chk("R1", "bus_hit ula=3", {15'd0, bus_hit}, 16'd1);
    ula = 3'd2;
    #1;
    chk("R1", "bus_hit ula=2", {15'd0, bus_hit}, 16'd0);
    bus_addr = 16'hFE8C;
    #1;
    chk("R1", "high word in ula=2 window", bus_rdata, 16'h2222 ^ 16'h2222 ^ 16'hA5A5);
    bus_valid = 0;
    @(negedge clk);
    ula = 3'd3;

    // R10: reset in the middle of use
    idle();
    arm = 1;
    @(negedge clk);
    idle();
    rst_n = 0;
    @(negedge clk);
    peek_resp("R10", 16'h39FF, 1'b0);
    rst_n = 1;
    @(negedge clk);
    idle();
    bus_valid = 1; bus_addr = 16'hFECC;
    #1;
    chk("R10", "high word after reset", bus_rdata, 16'h0000);
    @(negedge clk);
    idle();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule